// File: doc/BRIEF.md
# Second-Tick Watchdog Timer

This peripheral guards a system against stalled software. Once it is switched on, it counts a one-second tick input. If software does not restart the count within a chosen window of a power-of-two number of seconds, the block raises an interrupt. Depending on a configuration field, it may also raise a reset request. Software sets the window through a small code: the timeout is two raised to the code minus three, in seconds. Code 3 gives one second and code 10 gives 128 seconds.

Software talks to the block through a simple register port. Every request is accepted in the cycle it is presented, so the port applies no back-pressure. Each read returns its data exactly one cycle later on a response strobe, and the requester must take the response in that cycle. Writes produce no response. Three registers are mapped. The window code is at 0x3004 in bits 3:0. The expiry action is at 0x3008 in bits 1:0. The control word is at 0x300C, with run at bit 0, restart at bit 1 and an acknowledge flag at bit 8. Software sets restart to kick the watchdog, then polls the acknowledge flag until the restart has reached the counter. Before it reprograms the window, software clears run and waits for the flag to return to 0.

Top module: `sec_watchdog`

## Requirements
- R1: After reset every mapped register reads 0, `wdt_irq`, `wdt_rst_req` and `rsp_valid` are low, and the watchdog is stopped.
- R2: A read accepted at a clock edge returns its data on `rsp_rdata`, with `rsp_valid` high, for exactly the following cycle. The window code reads back in bits 3:0 and the action field in bits 1:0, with all other bits 0. An unmapped address reads 0.
- R3: The restart bit (bit 1 of 0x300C) always reads back as 0.
- R4: A control write that sets run while the watchdog is stopped, or that sets run and restart together, sets the acknowledge flag (bit 8) two cycles after the write is accepted. The flag then stays 1 while the watchdog runs.
- R5: Writing run = 0 stops the count. One cycle after that write is accepted, the acknowledge flag, `wdt_irq` and `wdt_rst_req` are all 0. Ticks have no effect while the watchdog is stopped.
- R6: With window code c in 3..10, expiry takes place on the 2^(c-3)-th tick counted after the last restart. A tick presented in the cycle of a restart is not counted.
- R7: A restart before expiry starts the count again from zero, which delays expiry by a full window.
- R8: At expiry `wdt_irq` rises. `wdt_rst_req` rises with it unless the action field equals 2, in which case only the interrupt is raised. Action values 0, 1 and 3 raise both outputs.
- R9: The expiry outputs stay asserted until the next restart or until run is cleared.
- R10: Window codes below 3 behave as code 3 (one tick), and codes above 10 behave as code 10 (128 ticks).
- R11: A restart applies the window code held at that moment, even while the watchdog is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request strobe, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data is valid this cycle |
| rsp_rdata | output | DATA_W | Read data |
| sec_tick | input | 1 | One-cycle pulse once per second |
| wdt_irq | output | 1 | Expiry interrupt, level, sticky |
| wdt_rst_req | output | 1 | Expiry reset request, level, sticky |

## Verification
The checker assumes that requests follow the register-port rules: a read must be ready to accept its response in the next cycle, and `sec_tick` lasts one cycle. It relies on this when it ties each response to the read one cycle earlier and ties each rise of the acknowledge flag to a restart two cycles earlier. The stimulus drives every request and tick for one cycle only, on the falling edge. It waits one idle cycle after each restart before it sends ticks, so that the tick count it expects matches R6.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CODE_W   = 4;
  localparam int ACT_W    = 2;
  localparam int CODE_MIN = 3;
  localparam int CODE_MAX = 10;
  localparam int CNT_W    = CODE_MAX - CODE_MIN + 1;

  localparam logic [15:0] OFS_WINDOW = 16'h3004;
  localparam logic [15:0] OFS_ACTION = 16'h3008;
  localparam logic [15:0] OFS_CTRL   = 16'h300C;

  localparam int BIT_RUN  = 0;
  localparam int BIT_KICK = 1;
  localparam int BIT_ACK  = 8;

  localparam logic [ACT_W-1:0] ACT_IRQ_ONLY = 2'd2;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_WINDOW,
    SEL_ACTION,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ack_flag,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [CODE_W-1:0] window_code,
  output logic [ACT_W-1:0]  action_sel,
  output logic              run_q,
  output logic              kick_q
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_go;
  logic              rd_go;

  assign wr_go = req_valid && req_write;
  assign rd_go = req_valid && !req_write;

  always_comb begin
    sel = SEL_NONE;
    if (req_addr == ADDR_W'(OFS_WINDOW))      sel = SEL_WINDOW;
    else if (req_addr == ADDR_W'(OFS_ACTION)) sel = SEL_ACTION;
    else if (req_addr == ADDR_W'(OFS_CTRL))   sel = SEL_CTRL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window_code <= '0;
      action_sel  <= '0;
      run_q       <= 1'b0;
      kick_q      <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      if (wr_go) begin
        case (sel)
          SEL_WINDOW: window_code <= req_wdata[CODE_W-1:0];
          SEL_ACTION: action_sel  <= req_wdata[ACT_W-1:0];
          SEL_CTRL: begin
            run_q  <= req_wdata[BIT_RUN];
            kick_q <= req_wdata[BIT_RUN] && (req_wdata[BIT_KICK] || !run_q);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_WINDOW: rd_mux[CODE_W-1:0] = window_code;
      SEL_ACTION: rd_mux[ACT_W-1:0]  = action_sel;
      SEL_CTRL: begin
        rd_mux[BIT_RUN] = run_q;
        rd_mux[BIT_ACK] = ack_flag;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_go;
      if (rd_go) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wdt_window_dec.sv
module wdt_window_dec #(
  parameter int CODE_W   = 4,
  parameter int CODE_MIN = 3,
  parameter int CODE_MAX = 10,
  parameter int CNT_W    = 8
) (
  input  logic [CODE_W-1:0] code,
  output logic [CNT_W-1:0]  limit
);
  localparam int N_CODES = 2 ** CODE_W;

  logic [CNT_W-1:0] table_q [N_CODES];

  for (genvar g = 0; g < N_CODES; g++) begin : g_tbl
    localparam int CLAMPED = (g < CODE_MIN) ? CODE_MIN : ((g > CODE_MAX) ? CODE_MAX : g);
    assign table_q[g] = CNT_W'(1) << (CLAMPED - CODE_MIN);
  end

  assign limit = table_q[code];
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             irq_only,
  output logic             ack_flag,
  output logic             irq,
  output logic             rst_req
);
  localparam int PIPE_W = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 1;

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [PIPE_W-1:0] pipe;

  assign cnt_nxt = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pipe     <= '0;
      ack_flag <= 1'b0;
    end else begin
      pipe[0] <= kick;
      for (int i = 1; i < PIPE_W; i++) pipe[i] <= pipe[i-1];
      if (pipe[PIPE_W-1]) ack_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt     <= '0;
      limit_q <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (kick) begin
      cnt     <= '0;
      limit_q <= limit;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else if (tick && !irq) begin
      if (cnt_nxt == limit_q) begin
        irq     <= 1'b1;
        rst_req <= !irq_only;
      end
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              sec_tick,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  logic [CODE_W-1:0] window_code;
  logic [ACT_W-1:0]  action_sel;
  logic              wd_run;
  logic              wd_kick;
  logic              wd_ack;
  logic [CNT_W-1:0]  limit;

  wdt_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ack_flag    (wd_ack),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .window_code (window_code),
    .action_sel  (action_sel),
    .run_q       (wd_run),
    .kick_q      (wd_kick)
  );

  wdt_window_dec #(
    .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .CNT_W(CNT_W)
  ) u_dec (
    .code  (window_code),
    .limit (limit)
  );

  wdt_core #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (wd_run),
    .kick     (wd_kick),
    .tick     (sec_tick),
    .limit    (limit),
    .irq_only (action_sel == ACT_IRQ_ONLY),
    .ack_flag (wd_ack),
    .irq      (wdt_irq),
    .rst_req  (wdt_rst_req)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              wdt_irq,
  input logic              wdt_rst_req,
  input logic              wd_run,
  input logic              wd_kick,
  input logic              wd_ack
);
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid); // R2
  AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R2
  AST_KICK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_addr) == ADDR_W'(OFS_CTRL)) |-> !rsp_rdata[BIT_KICK]); // R3
  AST_ACK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_ack) |-> $past(wd_kick, 2)); // R4
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_run |=> (!wdt_irq && !wdt_rst_req && !wd_ack)); // R5
  AST_EXPIRE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq) |-> $past(wd_run)); // R6
  AST_RST_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_req |-> wdt_irq); // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_irq && wd_run && !wd_kick) |=> wdt_irq); // R9
endmodule

bind sec_watchdog wdt_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .wdt_irq     (wdt_irq),
  .wdt_rst_req (wdt_rst_req),
  .wd_run      (wd_run),
  .wd_kick     (wd_kick),
  .wd_ack      (wd_ack)
);

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam logic [15:0] A_WIN  = 16'h3004;
  localparam logic [15:0] A_ACT  = 16'h3008;
  localparam logic [15:0] A_CTRL = 16'h300C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_rdata;
  logic              sec_tick = 1'b0;
  logic              wdt_irq;
  logic              wdt_rst_req;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DATA_W-1:0] exp_q [$];
  string             tag_q [$];
  bit                done = 1'b0;

  always #5 clk = ~clk;

  sec_watchdog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .sec_tick(sec_tick), .wdt_irq(wdt_irq),
    .wdt_rst_req(wdt_rst_req)
  );

  task automatic check(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected response", rsp_rdata, '0);
        n_fails += (rsp_rdata === '0) ? 1 : 0;
      end else begin
        check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(logic [15:0] a, logic [DATA_W-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, logic [DATA_W-1:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
    end
  endtask

  task automatic outs(string tag, logic irq_e, logic rst_e);
    check({tag, " irq"}, DATA_W'(wdt_irq), DATA_W'(irq_e));
    check({tag, " rst_req"}, DATA_W'(wdt_rst_req), DATA_W'(rst_e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    outs("R1", 1'b0, 1'b0);
    check("R1 rsp_valid", DATA_W'(rsp_valid), '0);
    rd(A_WIN, 32'h0, "R1 window");
    rd(A_ACT, 32'h0, "R1 action");
    rd(A_CTRL, 32'h0, "R1 ctrl");
    // R2 readback and field widths
    wr(A_WIN, 32'hFFF5);
    wr(A_ACT, 32'hFFFC);
    rd(A_WIN, 32'h5, "R2 window field");
    rd(A_ACT, 32'h0, "R2 action field");
    rd(16'h3000, 32'h0, "R2 unmapped");
    // R4 / R3 ack after run+restart
    wr(A_CTRL, 32'h3);
    rd(A_CTRL, 32'h1, "R3 R4 ack not yet");
    rd(A_CTRL, 32'h1, "R4 ack not yet");
    rd(A_CTRL, 32'h101, "R4 ack set");
    // R6 code 5 -> 4 ticks, R8 both outputs
    ticks(3);
    outs("R6 before window", 1'b0, 1'b0);
    ticks(1);
    outs("R6 R8 expiry", 1'b1, 1'b1);
    ticks(2); idle(2);
    outs("R9 sticky", 1'b1, 1'b1);
    rd(A_CTRL, 32'h101, "R4 ack holds");
    // R9 cleared by restart, R7 restart delays expiry
    wr(A_CTRL, 32'h3); idle(1);
    outs("R9 cleared by restart", 1'b0, 1'b0);
    ticks(3);
    wr(A_CTRL, 32'h3); idle(1);
    ticks(3);
    outs("R7 restarted count", 1'b0, 1'b0);
    ticks(1);
    outs("R7 expiry after full window", 1'b1, 1'b1);
    // R5 stop
    wr(A_CTRL, 32'h0); idle(1);
    outs("R5 R9 stop clears", 1'b0, 1'b0);
    rd(A_CTRL, 32'h0, "R5 ack cleared");
    ticks(10);
    outs("R5 ticks ignored", 1'b0, 1'b0);
    // R8 irq only, R11 new window on run+restart
    wr(A_ACT, 32'h2);
    wr(A_WIN, 32'h3);
    wr(A_CTRL, 32'h3); idle(1);
    ticks(1);
    outs("R8 R11 irq only", 1'b1, 1'b0);
    // R8 action 3 acts like 0
    wr(A_ACT, 32'h3);
    wr(A_CTRL, 32'h3); idle(1);
    outs("R8 restart clears", 1'b0, 1'b0);
    ticks(1);
    outs("R8 action 3", 1'b1, 1'b1);
    // R10 clamp low
    wr(A_CTRL, 32'h0);
    wr(A_WIN, 32'h0);
    wr(A_CTRL, 32'h3); idle(1);
    ticks(1);
    outs("R10 code 0 one tick", 1'b1, 1'b1);
    // R11 restart while running loads new code; R10 clamp high
    wr(A_WIN, 32'hF);
    wr(A_CTRL, 32'h3); idle(1);
    ticks(127);
    outs("R10 R11 code 15 before 128", 1'b0, 1'b0);
    ticks(1);
    outs("R10 R11 code 15 at 128", 1'b1, 1'b1);
    // R4 run without restart from stopped
    wr(A_CTRL, 32'h0); idle(1);
    wr(A_CTRL, 32'h1);
    rd(A_CTRL, 32'h1, "R4 run only pending");
    rd(A_CTRL, 32'h1, "R4 run only pending");
    rd(A_CTRL, 32'h101, "R4 run only ack");
    idle(3);
    check("R2 scoreboard drained", DATA_W'(exp_q.size()), '0);
    done = 1'b1;
    report();
  end
endmodule